// File: doc/BRIEF.md
# Paired-Mode Dual Event Counter

This block counts processor events on two 20-bit counters. A single pairing select chooses which events the two counters see together. Three legal pairings exist, and no event can be picked for one counter on its own. The host drives a one-cycle command port. Through it the host loads either or both counters, sets or clears their enables with a bitmask, changes the pairing and acknowledges interrupts. A single packed status word shows both counter values at the same moment.

To sample every N events, software loads the two's-complement negative of N into a counter. When the counter steps from all-ones to zero, it raises a sticky interrupt that names the counter that wrapped. A load placed too close to the wrap point is pulled back to a safe minimum distance, and this distance differs per counter. Counting is aggregate and takes no account of privilege or idle state.

Top module: `pmc_pair_unit`

## Requirements
- R1: An enabled counter adds one on each clock edge where its routed event strobe is high, and it wraps from 0xFFFFF to 0x00000.
- R2: `stat_word` carries counter 0 in bits 19:0 and counter 1 in bits 43:24. Bits 23:20 and 47:44 are always zero. Both fields reflect the same clock edge.
- R3: A pairing command (op 4) takes `cmd_value[1:0]`. Code 0 routes retired instructions to counter 0 and cycles to counter 1. Code 1 routes instructions to counter 0 and cache misses to counter 1. Code 2 routes cycles to counter 0 and replay traps to counter 1. Code 3 is ignored and leaves the pairing unchanged.
- R4: A load command (op 1) writes `cmd_value` into each counter whose `cmd_mask` bit is set, where bit i selects counter i. Unselected counters keep counting normally. A load wins over a count in the same cycle.
- R5: A loaded value above 0xFFFF0 is stored as 0xFFFF0 on counter 0 (at least 16 counts to wrap). A loaded value above 0xFFFFC is stored as 0xFFFFC on counter 1 (at least 4 counts to wrap).
- R6: An enable command (op 2) sets the enable bits given in `cmd_mask`, and a disable command (op 3) clears them. A disabled counter holds its value whatever its events do.
- R7: A wrap of counter i sets `irq` and records i as pending. `irq` stays high until every pending wrap has been acknowledged with op 5.
- R8: `irq_idx` is 0 while counter 0 has a pending wrap and is 1 otherwise when counter 1 has one. Each acknowledge clears only the reported wrap, so a simultaneous double wrap reports counter 0 first and then counter 1. A wrap in the same cycle as an acknowledge stays pending.
- R9: After reset both counters read zero, both are disabled, the pairing is code 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_cycle | input | 1 | Cycle event strobe |
| ev_instr | input | 1 | Retired instruction strobe |
| ev_miss | input | 1 | Second-level cache miss strobe |
| ev_replay | input | 1 | Memory-unit replay trap strobe |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 1 load, 2 enable, 3 disable, 4 pairing, 5 acknowledge |
| cmd_mask | input | 2 | Per-counter select, bit i for counter i |
| cmd_value | input | 20 | Load value or pairing code |
| stat_word | output | 48 | Packed counter values |
| en_mask | output | 2 | Current counter enables |
| pair_mode | output | 2 | Current pairing code |
| irq | output | 1 | Sticky wrap interrupt |
| irq_idx | output | 1 | Counter reported by the interrupt |

## Verification
Two pairs of functions can fall in the same cycle. A host load or enable change can meet an event strobe, and an acknowledge can meet a fresh wrap of either counter. Directed sequences step both counters to 0xFFFFF together and then wrap them on the same edge. In that sequence an acknowledge is issued while the other counter wraps. Random traffic biases loads toward the clamp region, so loads, counts and wraps keep colliding. A bench-side model judges every cycle's status word, enables, pairing, interrupt flag and index.

// File: rtl/pmc_pair_pkg.sv
package pmc_pair_pkg;
   localparam int NCTR = 2;

   typedef enum logic [1:0] {
      PAIR_INSTR_CYC   = 2'd0,
      PAIR_INSTR_MISS  = 2'd1,
      PAIR_CYC_REPLAY  = 2'd2,
      PAIR_BAD         = 2'd3
   } pair_mode_e;

   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_LOAD    = 3'd1,
      OP_ENABLE  = 3'd2,
      OP_DISABLE = 3'd3,
      OP_PAIR    = 3'd4,
      OP_ACK     = 3'd5
   } cmd_op_e;
endpackage

// File: rtl/pmc_event_route.sv
module pmc_event_route
   import pmc_pair_pkg::*;
(
   input  pair_mode_e          mode,
   input  logic                ev_cycle,
   input  logic                ev_instr,
   input  logic                ev_miss,
   input  logic                ev_replay,
   output logic [NCTR-1:0]     evt
);
   always_comb begin
      unique case (mode)
         PAIR_INSTR_CYC:  evt = {ev_cycle,  ev_instr};
         PAIR_INSTR_MISS: evt = {ev_miss,   ev_instr};
         PAIR_CYC_REPLAY: evt = {ev_replay, ev_cycle};
         default:         evt = '0;
      endcase
   end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
   parameter int CW  = 20,
   parameter int GAP = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          en_set,
   input  logic          en_clr,
   input  logic          evt,
   output logic [CW-1:0] cnt,
   output logic          en,
   output logic          wrap
);
   localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};
   localparam logic [CW-1:0] LIMIT    = ALL_ONES - CW'(GAP - 1);

   if (GAP < 1) begin : g_gap_low
      $error("pmc_counter: GAP must be at least 1");
   end
   if (CW < 4 || CW > 31) begin : g_cw_bad
      $error("pmc_counter: CW out of range");
   end

   logic [CW-1:0] load_clamped;
   logic          step;

   assign load_clamped = (load_val > LIMIT) ? LIMIT : load_val;
   assign step         = en & evt & ~load;
   assign wrap         = step & (cnt == ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         en  <= 1'b0;
      end else begin
         if (load)      cnt <= load_clamped;
         else if (step) cnt <= cnt + 1'b1;
         en <= (en | en_set) & ~en_clr;
      end
   end
endmodule

// File: rtl/pmc_irq_queue.sv
module pmc_irq_queue
   import pmc_pair_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCTR-1:0] wrap,
   input  logic            ack,
   output logic            irq,
   output logic            irq_idx
);
   logic [NCTR-1:0] pend;
   logic [NCTR-1:0] clr;

   assign clr[0]  = ack & pend[0];
   assign clr[1]  = ack & ~pend[0] & pend[1];
   assign irq     = |pend;
   assign irq_idx = ~pend[0] & pend[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr) | wrap;
   end
endmodule

// File: rtl/pmc_pair_unit.sv
module pmc_pair_unit
   import pmc_pair_pkg::*;
#(
   parameter int CW   = 20,
   parameter int SLOT = 24,
   parameter int GAP0 = 16,
   parameter int GAP1 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_cycle,
   input  logic              ev_instr,
   input  logic              ev_miss,
   input  logic              ev_replay,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [1:0]        cmd_mask,
   input  logic [CW-1:0]     cmd_value,
   output logic [2*SLOT-1:0] stat_word,
   output logic [1:0]        en_mask,
   output logic [1:0]        pair_mode,
   output logic              irq,
   output logic              irq_idx
);
   localparam int PAD = SLOT - CW;

   if (SLOT < CW) begin : g_slot_bad
      $error("pmc_pair_unit: SLOT narrower than CW");
   end

   pair_mode_e      mode_q;
   logic [NCTR-1:0] evt;
   logic [NCTR-1:0] wrap;
   logic            is_load, is_en, is_dis, is_pair, is_ack;

   assign is_load = cmd_valid && cmd_op == OP_LOAD;
   assign is_en   = cmd_valid && cmd_op == OP_ENABLE;
   assign is_dis  = cmd_valid && cmd_op == OP_DISABLE;
   assign is_pair = cmd_valid && cmd_op == OP_PAIR;
   assign is_ack  = cmd_valid && cmd_op == OP_ACK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= PAIR_INSTR_CYC;
      else if (is_pair && cmd_value[1:0] != PAIR_BAD)
         mode_q <= pair_mode_e'(cmd_value[1:0]);
   end
   assign pair_mode = mode_q;

   pmc_event_route u_route (
      .mode      (mode_q),
      .ev_cycle  (ev_cycle),
      .ev_instr  (ev_instr),
      .ev_miss   (ev_miss),
      .ev_replay (ev_replay),
      .evt       (evt)
   );

   for (genvar i = 0; i < NCTR; i++) begin : g_ctr
      localparam int GAP_I = (i == 0) ? GAP0 : GAP1;
      logic [CW-1:0] cnt;
      pmc_counter #(.CW(CW), .GAP(GAP_I)) u_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (is_load & cmd_mask[i]),
         .load_val (cmd_value),
         .en_set   (is_en & cmd_mask[i]),
         .en_clr   (is_dis & cmd_mask[i]),
         .evt      (evt[i]),
         .cnt      (cnt),
         .en       (en_mask[i]),
         .wrap     (wrap[i])
      );
      if (PAD > 0) begin : g_pad
         assign stat_word[i*SLOT +: SLOT] = {{PAD{1'b0}}, cnt};
      end else begin : g_nopad
         assign stat_word[i*SLOT +: SLOT] = cnt;
      end
   end

   pmc_irq_queue u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .ack     (is_ack),
      .irq     (irq),
      .irq_idx (irq_idx)
   );
endmodule

// File: rtl/pmc_pair_chk.sv
module pmc_pair_chk #(
   parameter int CW   = 20,
   parameter int SLOT = 24,
   parameter int GAP0 = 16,
   parameter int GAP1 = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic [1:0]        cmd_mask,
   input logic [CW-1:0]     cmd_value,
   input logic [2*SLOT-1:0] stat_word,
   input logic [1:0]        en_mask,
   input logic [1:0]        pair_mode,
   input logic              irq,
   input logic              irq_idx
);
   localparam logic [CW-1:0] LIM0 = {CW{1'b1}} - CW'(GAP0 - 1);
   localparam logic [CW-1:0] LIM1 = {CW{1'b1}} - CW'(GAP1 - 1);

   // R2
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[SLOT-1:CW] == '0 && stat_word[2*SLOT-1:SLOT+CW] == '0);

   // R3
   pair_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd4 && cmd_value[1:0] == 2'd3) |=> $stable(pair_mode));

   // R5
   clamp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd1 && cmd_mask[0]) |=> stat_word[CW-1:0] <= LIM0);

   // R5
   clamp1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd1 && cmd_mask[1]) |=> stat_word[SLOT+CW-1:SLOT] <= LIM1);

   // R6
   hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_mask[0] && !(cmd_valid && cmd_op == 3'd1 && cmd_mask[0]))
      |=> stat_word[CW-1:0] == $past(stat_word[CW-1:0]));

   // R7
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(cmd_valid && cmd_op == 3'd5)) |=> irq);

   // R8
   idx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> !irq_idx);
endmodule

bind pmc_pair_unit pmc_pair_chk #(.CW(CW), .SLOT(SLOT), .GAP0(GAP0), .GAP1(GAP1)) chk_i (.*);

// File: tb/pmc_pair_unit_tb.sv
module pmc_pair_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SEED       = 1357;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_cycle = 0, ev_instr = 0, ev_miss = 0, ev_replay = 0;
   logic        cmd_valid = 0;
   logic [2:0]  cmd_op = 0;
   logic [1:0]  cmd_mask = 0;
   logic [19:0] cmd_value = 0;
   logic [47:0] stat_word;
   logic [1:0]  en_mask, pair_mode;
   logic        irq, irq_idx;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [19:0] m0, m1;
   logic [1:0]  men, mmode, mpend;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmc_pair_unit dut_i (.*);

   function automatic logic [19:0] clampv(logic [19:0] v, int gap);
      logic [19:0] lim = 20'hFFFFF - 20'(gap - 1);
      return (v > lim) ? lim : v;
   endfunction

   task automatic chk(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(stat_word[19:0] == m0, "R1 counter0", stat_word[19:0], m0);
      chk(stat_word[43:24] == m1, "R1 counter1", stat_word[43:24], m1);
      chk(stat_word[23:20] == 0 && stat_word[47:44] == 0, "R2 pad", stat_word, 0);
      chk(en_mask == men, "R6 enables", en_mask, men);
      chk(pair_mode == mmode, "R3 pairing", pair_mode, mmode);
      chk(irq == (mpend != 0), "R7 irq", irq, mpend != 0);
      chk(irq_idx == (~mpend[0] & mpend[1]), "R8 idx", irq_idx, ~mpend[0] & mpend[1]);
   endtask

   // ev = {replay, miss, instr, cycle}
   task automatic cyc(logic [3:0] ev, logic [2:0] op, logic [1:0] mask, logic [19:0] val);
      logic e0, e1, ld0, ld1, w0, w1;
      logic [1:0] clr;
      @(negedge clk);
      {ev_replay, ev_miss, ev_instr, ev_cycle} = ev;
      cmd_valid = (op != 0);
      cmd_op = op; cmd_mask = mask; cmd_value = val;
      case (mmode)
         2'd0: begin e0 = ev[1]; e1 = ev[0]; end
         2'd1: begin e0 = ev[1]; e1 = ev[2]; end
         default: begin e0 = ev[0]; e1 = ev[3]; end
      endcase
      ld0 = (op == 1) && mask[0];
      ld1 = (op == 1) && mask[1];
      w0 = men[0] & e0 & ~ld0 & (m0 == 20'hFFFFF);
      w1 = men[1] & e1 & ~ld1 & (m1 == 20'hFFFFF);
      clr = 2'b00;
      if (op == 5) clr = mpend[0] ? 2'b01 : {mpend[1], 1'b0};
      @(posedge clk);
      if (ld0) m0 = clampv(val, 16); else if (men[0] & e0) m0 = m0 + 1;
      if (ld1) m1 = clampv(val, 4);  else if (men[1] & e1) m1 = m1 + 1;
      if (op == 2) men = men | mask;
      if (op == 3) men = men & ~mask;
      if (op == 4 && val[1:0] != 2'd3) mmode = val[1:0];
      mpend = (mpend & ~clr) | {w1, w0};
      #1;
      compare_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(SEED));
      m0 = 0; m1 = 0; men = 0; mmode = 0; mpend = 0;
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      chk(stat_word == 0, "R9 counters", stat_word, 0);
      chk(en_mask == 0 && pair_mode == 0 && !irq, "R9 ctrl", {en_mask, pair_mode, irq}, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;

      // R5 clamp on each counter, R4 selective load
      cyc(4'b0000, 3'd1, 2'b01, 20'hFFFFE);
      chk(stat_word[19:0] == 20'hFFFF0, "R5 clamp0", stat_word[19:0], 20'hFFFF0);
      chk(stat_word[43:24] == 0, "R4 unselected", stat_word[43:24], 0);
      cyc(4'b0000, 3'd1, 2'b10, 20'hFFFFF);
      chk(stat_word[43:24] == 20'hFFFFC, "R5 clamp1", stat_word[43:24], 20'hFFFFC);
      // R3 illegal code ignored
      cyc(4'b0000, 3'd4, 2'b00, 20'd3);
      chk(pair_mode == 0, "R3 bad code", pair_mode, 0);
      // R6 disabled counters hold
      cyc(4'b1111, 3'd0, 2'b00, 0);
      chk(stat_word[19:0] == 20'hFFFF0, "R6 hold", stat_word[19:0], 20'hFFFF0);

      // R8 simultaneous wrap: both at FFFF0 in pairing A, both enabled
      cyc(4'b0000, 3'd1, 2'b11, 20'hFFFF0);
      cyc(4'b0000, 3'd2, 2'b11, 0);
      for (int k = 0; k < 15; k++) cyc(4'b0011, 3'd0, 0, 0);
      chk(stat_word[43:24] == 20'hFFFFF, "R1 at top", stat_word[43:24], 20'hFFFFF);
      cyc(4'b0011, 3'd0, 0, 0);
      chk(irq && !irq_idx, "R8 first idx0", {irq, irq_idx}, 2'b10);
      chk(stat_word[19:0] == 0, "R1 wrap", stat_word[19:0], 0);
      cyc(4'b0000, 3'd5, 0, 0);
      chk(irq && irq_idx, "R8 then idx1", {irq, irq_idx}, 2'b11);
      cyc(4'b0000, 3'd0, 0, 0);
      chk(irq, "R7 sticky", irq, 1);
      cyc(4'b0000, 3'd5, 0, 0);
      chk(!irq, "R7 cleared", irq, 0);

      // R8 wrap in same cycle as acknowledge
      cyc(4'b0000, 3'd1, 2'b10, 20'hFFFFC);
      cyc(4'b0001, 3'd0, 0, 0);
      cyc(4'b0001, 3'd0, 0, 0);
      cyc(4'b0001, 3'd0, 0, 0);
      cyc(4'b0001, 3'd5, 0, 0);
      chk(irq && irq_idx, "R8 ack+wrap", {irq, irq_idx}, 2'b11);
      cyc(4'b0000, 3'd5, 0, 0);

      // R4 load beats a count; R3 pairing C
      cyc(4'b0000, 3'd4, 0, 20'd2);
      cyc(4'b0001, 3'd1, 2'b01, 20'h00100);
      chk(stat_word[19:0] == 20'h00100, "R4 load wins", stat_word[19:0], 20'h00100);

      // random traffic
      for (int n = 0; n < 6000; n++) begin
         logic [2:0] op;
         logic [19:0] v;
         int r = $urandom_range(0, 99);
         op = (r < 80) ? 3'd0 : 3'($urandom_range(1, 5));
         v = ($urandom_range(0, 1) != 0) ? (20'hFFFE0 | 20'($urandom_range(0, 31)))
                                         : 20'($urandom);
         if (op == 4) v = 20'($urandom_range(0, 3));
         cyc(4'($urandom), op, 2'($urandom), v);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule